// File: doc/BRIEF.md
# SPI Master EEPROM Read Sequencer

This block is the transfer engine of an SPI master for one sequence: reading from a serial EEPROM. It runs in SPI mode 0 with fixed-width frames. A transfer has two phases that share one continuous run of the serial clock under one slave select.

In the control phase, the engine pulls frames from a transmit FIFO and shifts them out on `txd`. For an EEPROM these frames are normally an 8-bit opcode, then the upper address byte, then the lower address byte. Bits that arrive on `rxd` during these frames are thrown away.

At the first frame boundary where the transmit FIFO is empty, the engine switches to the read phase. It keeps clocking, holds `txd` at a fixed level, and writes each completed incoming frame into a receive FIFO. The transfer stops once the programmed frame count plus one frames have been received.

A transfer starts by itself when all four of these hold: the block is enabled, it is set up as a master, the EEPROM read mode is selected, and the transmit FIFO is not empty. Clearing the enable stops a transfer at once and puts the serial pins back in their idle state. The serial clock comes from the system clock through an even divider.

Top module: `spi_eeprom_rd_master`

## Requirements
- R1: A transfer starts only when `enable`=1, `master_sel`=1, `xfer_mode`=3 and `tx_empty`=0 all hold together. With any of them missing, no frame is popped, `sclk` stays 0 and `ss_n` stays 1. After reset, `sclk`=0, `ss_n`=1, and `done`, `overflow`, `rx_push` and `tx_pop` are all 0.
- R2: SPI mode 0 timing. `sclk` idles at 0 whenever `ss_n` is 1. `txd` changes only while `sclk` is low. `rxd` is sampled on rising `sclk` edges, most significant bit first. The `sclk` period is `clk_div` system clock cycles: an odd value is rounded down, and values 0 and 1 act as 2.
- R3: Control frames are popped from the transmit FIFO (`tx_pop`=1 in the cycle that accepts `tx_data`), one at the start of each control frame, and sent MSB first. The engine keeps sending while the FIFO holds data, and the FIFO is empty when the transfer ends.
- R4: No `rx_push` occurs for any frame that drives data on `txd`.
- R5: In the read phase, each completed frame produces a one-cycle `rx_push`, with `rx_data` holding the byte in first-bit-in-MSB order.
- R6: During read-phase frames, `txd` is held at 0.
- R7: The transfer ends after `frame_cnt`+1 read frames. In the cycle that ends it, `ss_n` returns to 1 and `done` pulses for exactly one cycle. `ss_n` stays 0 from the first control bit until then.
- R8: If `rx_full` is 1 when a read frame completes, that frame is dropped and `overflow` is set. The flag stays set until the next transfer starts.
- R9: When `enable` is 0, the next cycle has `sclk`=0 and `ss_n`=1, and no `done` or `rx_push` is raised for the aborted transfer.
- R10: Transmit frames beyond the control frames are still sent. The read data that arrives during them is lost, and the read phase still collects `frame_cnt`+1 frames after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low aborts and idles the pins |
| master_sel | input | 1 | 1 when the block acts as an SPI master |
| xfer_mode | input | 2 | Transfer mode select; 3 selects EEPROM read |
| frame_cnt | input | CNT_W | Number of read frames minus one |
| clk_div | input | DIV_W | System clocks per sclk period (even, at least 2) |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | FRAME_W | Head entry of the transmit FIFO |
| tx_pop | output | 1 | Consume the transmit FIFO head this cycle |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | FRAME_W | Received frame |
| sclk | output | 1 | Serial clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| done | output | 1 | One-cycle pulse when a transfer completes |
| overflow | output | 1 | Sticky receive drop flag |

## Verification
The bench builds the block with `CNT_W`=4 and `DIV_W`=5, and keeps 8-bit MSB-first frames. With the narrow count, the largest frame count of 15 (sixteen read frames) fits easily within the run time. With the narrow divider, the clamped values 0 and 1, odd values, and every even period up to 8 can all be reached. Under these settings the bench also drives extra control frames and a full receive FIFO, so the displacement and drop paths each occur several times.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CTRL = 2'd1,
      SEQ_READ = 2'd2
   } seq_state_t;
endpackage

// File: rtl/spi_rd_clkdiv.sv
// Half-period tick generator for the serial clock.
module spi_rd_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int HW = DIV_W - 1;

   logic [HW-1:0] half;
   logic [HW-1:0] cnt_q;

   // odd divisors round down, 0 and 1 clamp to a half period of one cycle
   always_comb begin
      if (div[DIV_W-1:1] == '0) half = HW'(1);
      else                      half = div[DIV_W-1:1];
   end

   assign tick = run && (cnt_q == half - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + HW'(1);
   end
endmodule

// File: rtl/spi_rd_shifter.sv
// Transmit and receive shift registers; bit order chosen by parameter.
module spi_rd_shifter #(
   parameter int FRAME_W   = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_data,
   input  logic               shift,
   input  logic               sample,
   input  logic               rxd,
   output logic               tx_bit,
   output logic [FRAME_W-1:0] rx_word
);
   logic [FRAME_W-1:0] tx_q, tx_nxt, rx_q, rx_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign tx_bit = tx_q[FRAME_W-1];
         assign tx_nxt = {tx_q[FRAME_W-2:0], 1'b0};
         assign rx_nxt = {rx_q[FRAME_W-2:0], rxd};
      end else begin : g_lsb
         assign tx_bit = tx_q[0];
         assign tx_nxt = {1'b0, tx_q[FRAME_W-1:1]};
         assign rx_nxt = {rxd, rx_q[FRAME_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)       tx_q <= load_data;
         else if (shift) tx_q <= tx_nxt;
         if (sample)     rx_q <= rx_nxt;
      end
   end

   assign rx_word = rx_q;
endmodule

// File: rtl/spi_eeprom_rd_master.sv
module spi_eeprom_rd_master
   import spi_rd_pkg::*;
#(
   parameter int               FRAME_W   = 8,
   parameter int               CNT_W     = 8,
   parameter int               DIV_W     = 8,
   parameter logic [MODE_W-1:0] RD_MODE  = 2'd3,
   parameter bit               TXD_HOLD  = 1'b0,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               master_sel,
   input  logic [MODE_W-1:0]  xfer_mode,
   input  logic [CNT_W-1:0]   frame_cnt,
   input  logic [DIV_W-1:0]   clk_div,
   input  logic               tx_empty,
   input  logic [FRAME_W-1:0] tx_data,
   output logic               tx_pop,
   input  logic               rx_full,
   output logic               rx_push,
   output logic [FRAME_W-1:0] rx_data,
   output logic               sclk,
   output logic               txd,
   input  logic               rxd,
   output logic               ss_n,
   output logic               done,
   output logic               overflow
);
   localparam int               BIT_W    = $clog2(FRAME_W + 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
   endgenerate

   seq_state_t         state_q;
   logic               sclk_q, ss_n_q, done_q, ovf_q, push_q;
   logic [BIT_W-1:0]   bit_q;
   logic [CNT_W-1:0]   rx_cnt_q;
   logic [FRAME_W-1:0] rx_data_q;

   logic tick, rise, fall, frame_end, last_rx, go, next_ctrl, load, shift, busy;
   logic tx_bit;
   logic [FRAME_W-1:0] rx_word;

   assign busy      = (state_q != SEQ_IDLE);
   assign go        = (state_q == SEQ_IDLE) && enable && master_sel &&
                      (xfer_mode == RD_MODE) && !tx_empty;
   assign rise      = tick && !sclk_q;
   assign fall      = tick && sclk_q;
   assign frame_end = fall && (bit_q == BIT_LAST);
   assign last_rx   = (state_q == SEQ_READ) && (rx_cnt_q == frame_cnt);
   assign next_ctrl = frame_end && (state_q == SEQ_CTRL) && !tx_empty;
   assign load      = go || next_ctrl;
   assign shift     = fall && !frame_end;

   spi_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy && enable),
      .div   (clk_div),
      .tick  (tick)
   );

   spi_rd_shifter #(.FRAME_W(FRAME_W), .MSB_FIRST(MSB_FIRST)) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (tx_data),
      .shift     (shift),
      .sample    (rise),
      .rxd       (rxd),
      .tx_bit    (tx_bit),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         sclk_q    <= 1'b0;
         ss_n_q    <= 1'b1;
         done_q    <= 1'b0;
         ovf_q     <= 1'b0;
         push_q    <= 1'b0;
         bit_q     <= '0;
         rx_cnt_q  <= '0;
         rx_data_q <= '0;
      end else if (!enable) begin
         state_q <= SEQ_IDLE;
         sclk_q  <= 1'b0;
         ss_n_q  <= 1'b1;
         done_q  <= 1'b0;
         push_q  <= 1'b0;
         bit_q   <= '0;
      end else begin
         done_q <= 1'b0;
         push_q <= 1'b0;
         if (state_q == SEQ_IDLE) begin
            if (go) begin
               state_q  <= SEQ_CTRL;
               ss_n_q   <= 1'b0;
               sclk_q   <= 1'b0;
               bit_q    <= '0;
               rx_cnt_q <= '0;
               ovf_q    <= 1'b0;
            end
         end else begin
            if (rise) begin
               sclk_q <= 1'b1;
               bit_q  <= bit_q + BIT_W'(1);
            end
            if (fall) sclk_q <= 1'b0;
            if (frame_end) begin
               bit_q <= '0;
               if (state_q == SEQ_READ) begin
                  rx_cnt_q  <= rx_cnt_q + CNT_W'(1);
                  rx_data_q <= rx_word;
                  if (rx_full) ovf_q  <= 1'b1;
                  else         push_q <= 1'b1;
                  if (last_rx) begin
                     state_q <= SEQ_IDLE;
                     ss_n_q  <= 1'b1;
                     done_q  <= 1'b1;
                  end
               end else if (tx_empty) begin
                  state_q <= SEQ_READ;
               end
            end
         end
      end
   end

   assign tx_pop   = load;
   assign txd      = (state_q == SEQ_CTRL) ? tx_bit : TXD_HOLD;
   assign sclk     = sclk_q;
   assign ss_n     = ss_n_q;
   assign done     = done_q;
   assign overflow = ovf_q;
   assign rx_push  = push_q;
   assign rx_data  = rx_data_q;
endmodule

// Property checker attached to every instance of the sequencer.
module spi_rd_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic sclk,
   input logic txd,
   input logic ss_n,
   input logic tx_pop,
   input logic tx_empty,
   input logic rx_push,
   input logic rx_full,
   input logic done
);
   assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty);

   assert_txd_steady_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(txd));

   assert_sclk_idle_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> !sclk);

   assert_done_releases_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ss_n);

   assert_done_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !$past(rx_full));

   assert_disable_idles_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sclk && ss_n && !done && !rx_push));
endmodule

bind spi_eeprom_rd_master spi_rd_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .sclk     (sclk),
   .txd      (txd),
   .ss_n     (ss_n),
   .tx_pop   (tx_pop),
   .tx_empty (tx_empty),
   .rx_push  (rx_push),
   .rx_full  (rx_full),
   .done     (done)
);

// File: tb/spi_eeprom_rd_master_tb.sv
module spi_eeprom_rd_master_tb;
   localparam int FW = 8;
   localparam int CW = 4;
   localparam int DW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          master_sel = 1'b0;
   logic [1:0]    xfer_mode = 2'd0;
   logic [CW-1:0] frame_cnt = '0;
   logic [DW-1:0] clk_div = DW'(2);
   logic          tx_empty;
   logic [FW-1:0] tx_data;
   logic          tx_pop;
   logic          rx_full = 1'b0;
   logic          rx_push;
   logic [FW-1:0] rx_data;
   logic          sclk, txd, ss_n, done, overflow;
   logic          rxd = 1'b0;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   spi_eeprom_rd_master #(.FRAME_W(FW), .CNT_W(CW), .DIV_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .master_sel(master_sel),
      .xfer_mode(xfer_mode), .frame_cnt(frame_cnt), .clk_div(clk_div),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
      .sclk(sclk), .txd(txd), .rxd(rxd), .ss_n(ss_n), .done(done),
      .overflow(overflow)
   );

   // transmit FIFO model
   logic [7:0]  txq [0:15];
   int unsigned tx_rd = 0;
   int unsigned tx_wr = 0;
   assign tx_empty = (tx_rd == tx_wr);
   assign tx_data  = txq[tx_rd % 16];
   always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

   // EEPROM side model
   int        exp_ntx = 0;
   longint    exp_per = 8;
   logic [7:0] base = 8'h00;
   int        sf = 0, sb = 0, txd_bad = 0, per_bad = 0, nrise = 0;
   logic [7:0] tsh = 8'h00;
   logic [7:0] txrec [0:31];
   logic [7:0] cur;
   time        t_last = 0;

   function automatic logic [7:0] fbyte(input int k);
      return 8'(base + 8'(k) * 8'd37);
   endfunction

   always @(posedge sclk or negedge ss_n) begin
      if (!sclk) begin
         sf = 0; sb = 0; txd_bad = 0; per_bad = 0; nrise = 0;
         cur = fbyte(0);
         rxd = cur[7];
      end else if (!ss_n) begin
         tsh = {tsh[6:0], txd};
         if (sf >= exp_ntx && txd !== 1'b0) txd_bad++;
         if (nrise > 0 && longint'($time - t_last) != exp_per) per_bad++;
         t_last = $time;
         nrise++;
         sb++;
         if (sb == 8) begin
            if (sf < 32) txrec[sf] = tsh;
            sf++;
            sb = 0;
         end
         cur = fbyte(sf);
         rxd = cur[7-sb];
      end
   end

   int nrise_all = 0;
   always @(posedge sclk) nrise_all++;

   logic [7:0] pushed [0:511];
   int npush = 0, ndone = 0;
   always @(negedge clk) begin
      if (rx_push) begin
         if (npush < 512) pushed[npush] = rx_data;
         npush++;
      end
      if (done) ndone++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_xfer(input int ntx, input int n, input int div, input bit full);
      int np0, nd0, t, ep;
      logic [7:0] sent [0:7];
      logic [7:0] eb;
      ep      = (div < 2) ? 2 : (div & ~1);
      exp_ntx = ntx;
      exp_per = longint'(ep) * 4;
      base    = 8'($urandom);
      rx_full = full;
      frame_cnt = CW'(n);
      clk_div   = DW'(div);
      np0 = npush;
      nd0 = ndone;
      for (int i = 0; i < ntx; i++) begin
         sent[i] = 8'($urandom);
         txq[(tx_rd + i) % 16] = sent[i];
      end
      tx_wr = tx_rd + ntx;
      t = 0;
      while (ndone == nd0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
      chk(ndone == nd0 + 1, "R7", "done pulses", ndone - nd0, 1);
      for (int i = 0; i < ntx; i++)
         chk(txrec[i] == sent[i], "R3", "control frame", txrec[i], sent[i]);
      chk(npush - np0 == (full ? 0 : n + 1), "R4", "push count", npush - np0, full ? 0 : n + 1);
      if (!full) begin
         for (int i = 0; i <= n; i++) begin
            eb = fbyte(ntx + i);
            chk(pushed[np0 + i] == eb, (ntx > 3) ? "R10" : "R5", "read byte",
                pushed[np0 + i], eb);
         end
      end
      chk(sf == ntx + n + 1, "R7", "total frames", sf, ntx + n + 1);
      chk(txd_bad == 0, "R6", "txd not held low", txd_bad, 0);
      chk(per_bad == 0, "R2", "sclk period mismatches", per_bad, 0);
      chk(ss_n == 1'b1 && done == 1'b0, "R7", "select released, done low", {ss_n, done}, 2);
      chk(overflow == full, "R8", "overflow flag", overflow, full);
      chk(tx_empty == 1'b1, "R3", "transmit FIFO drained", tx_empty, 1);
   endtask

   task automatic expect_no_start(input string what);
      int r0;
      r0 = nrise_all;
      repeat (60) @(negedge clk);
      chk(ss_n == 1'b1 && nrise_all == r0, "R1", what, nrise_all - r0, 0);
      chk(tx_wr - tx_rd == 2, "R1", {what, " entries kept"}, tx_wr - tx_rd, 2);
   endtask

   initial begin
      #(4 * 200000);
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end

   initial begin
      int np0, nd0, r0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0 && ss_n == 1'b1, "R1", "reset pins", {sclk, ss_n}, 1);
      chk(done == 1'b0 && overflow == 1'b0 && rx_push == 1'b0 && tx_pop == 1'b0,
          "R1", "reset flags", {done, overflow, rx_push, tx_pop}, 0);

      // R1: each missing start condition blocks the transfer
      enable = 1'b1; master_sel = 1'b1; xfer_mode = 2'd1;
      txq[tx_rd % 16] = 8'h03; txq[(tx_rd + 1) % 16] = 8'h10;
      tx_wr = tx_rd + 2;
      expect_no_start("wrong mode");
      xfer_mode = 2'd3; master_sel = 1'b0;
      expect_no_start("not master");
      enable = 1'b0; master_sel = 1'b1;
      expect_no_start("disabled");
      tx_wr = tx_rd;
      @(negedge clk);
      enable = 1'b1;

      // directed cases
      run_xfer(3, 3, 2, 1'b0);
      run_xfer(3, 0, 4, 1'b0);
      run_xfer(5, 2, 4, 1'b0);   // R10: two surplus frames
      run_xfer(3, 4, 2, 1'b1);   // R8: receive FIFO full
      run_xfer(3, 2, 6, 1'b0);   // R8: flag cleared at next start
      run_xfer(3, 15, 2, 1'b0);  // R7: largest count
      run_xfer(3, 1, 1, 1'b0);   // R2: divisor 1 acts as 2
      run_xfer(3, 1, 5, 1'b0);   // R2: odd divisor rounds down

      // R9: abort in the middle of a transfer
      exp_ntx = 3; frame_cnt = CW'(5); clk_div = DW'(4); rx_full = 1'b0;
      for (int i = 0; i < 3; i++) txq[(tx_rd + i) % 16] = 8'($urandom);
      tx_wr = tx_rd + 3;
      repeat (40) @(negedge clk);
      np0 = npush; nd0 = ndone;
      enable = 1'b0;
      @(negedge clk);
      chk(sclk == 1'b0 && ss_n == 1'b1, "R9", "pins idle after disable", {sclk, ss_n}, 1);
      chk(txd == 1'b0, "R9", "txd idle after disable", txd, 0);
      r0 = nrise_all;
      repeat (100) @(negedge clk);
      chk(ndone == nd0 && npush == np0, "R9", "no done or push after abort",
          (ndone - nd0) + (npush - np0), 0);
      chk(nrise_all == r0, "R9", "sclk quiet while disabled", nrise_all - r0, 0);
      tx_wr = tx_rd;
      @(negedge clk);
      enable = 1'b1;

      // constrained random transfers
      for (int it = 0; it < 6; it++) begin
         run_xfer(1 + int'($urandom % 4), int'($urandom % 16),
                  2 * (1 + int'($urandom % 4)), 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule